// File: doc/BRIEF.md
# Daisy-Chainable Output/Fault Shift Register

This block is the serial slave of a multi-channel low-side switch. A host shifts one command bit per channel into a short shift chain on rising serial-clock edges while the latch line is low. A rising latch edge copies the chain into the output register that drives the channel switches. The last stage of the chain feeds the serial output, so several devices can share one bus with each output wired to the next device's input.

The same chain also carries status back to the host. After the latch line goes high, the first falling serial-clock edge snapshots the per-channel fault flags into the chain. Each later falling edge shifts them out, most significant channel first, and shifts in the upstream device's bits behind them. An active-low enable forces every channel output off but leaves the serial logic running. An active-high clear input empties both registers.

All serial pins are treated as asynchronous. They pass through a synchronizer of `SYNC_STAGES` flops and are edge-detected in the system clock domain, which must run several times faster than the serial clock. The fault flags are assumed to be already in the system clock domain.

Top module: `lsd_serial_slave`

## Requirements
- R1: After the synchronous active-low reset `rst_n`, `drive_o` and `sdat_o` are both 0.
- R2: While the synchronized latch line is low, each rising `sclk_i` edge shifts `sdat_i` into stage 0 and moves every stage up by one. The bit shifted in first ends in the top stage after `CHANNELS` edges, and that stage drives `drive_o[CHANNELS-1]`.
- R3: `sdat_o` always equals the top stage of the chain. In a two-device chain, the first bit of an 8-bit frame appears on `sdat_o` after four shifts and the second bit after five.
- R4: A rising latch edge copies the chain into the output register. The output register changes at no other time except through clear or reset, including while fault data is being read out.
- R5: Once the latch line is high, the first falling `sclk_i` edge loads `fault_i` into the chain, with `fault_i[i]` going to stage i. A falling edge in the same synchronized cycle as the latch rise also counts as that first edge. Rising `sclk_i` edges while the latch line is high are ignored, and `fault_i` is not sampled after the snapshot.
- R6: While the latch line is high, every falling `sclk_i` edge after the snapshot shifts `sdat_i` in as in R2.
- R7: Falling `sclk_i` edges while the latch line is low do not move the chain.
- R8: While `en_n_i` is high, `drive_o` is 0. The chain and the output register still update, and their value shows on `drive_o` once `en_n_i` is low again.
- R9: A high `clear_i` empties the chain and the output register, so `drive_o` and `sdat_o` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdat_i | input | 1 | Serial data in (from host or upstream device) |
| latch_i | input | 1 | Latch line: low = write phase, rising = update outputs, high = read phase |
| clear_i | input | 1 | Active-high clear of serial registers, asynchronous |
| en_n_i | input | 1 | Active-low output enable, asynchronous |
| fault_i | input | CHANNELS | Per-channel fault flags, system clock domain |
| sdat_o | output | 1 | Serial data out, top stage of chain |
| drive_o | output | CHANNELS | Channel switch commands, gated by enable |

## Verification
Three fixed frames are written: one with mixed bits, one that shows the first-in bit landing on the top channel, and one kept going for a fifth shift to show the chain passing bits downstream. A read-back with different fault flags, a mid-read change of those flags and chosen injected bits shows the snapshot timing, the falling-edge shift and the injected data coming out behind the faults. A case where the latch rise and the serial-clock fall reach the core together shows that this edge still counts as the snapshot. A long stretch of random frames, read lengths, enable toggles and clears is compared cycle by cycle with a behavioural model. This catches ordering mistakes between the write and read phases that the fixed frames cannot expose.

// File: rtl/lsd_ser_pkg.sv
// Package: shared types for the serial output/fault register.
// Assumes: the synchronized control vector uses the field order below.
package lsd_ser_pkg;

    // Synchronized view of the asynchronous serial pins.
    typedef struct packed {
        logic clear;
        logic en_n;
        logic latch;
        logic sclk;
        logic sdat;
    } ser_pins_t;

    localparam int PIN_W = $bits(ser_pins_t);

    // Per-cycle edge events seen by the control sequencer.
    typedef struct packed {
        logic sclk_rise;
        logic sclk_fall;
        logic latch_rise;
    } ser_events_t;

endpackage

// File: rtl/lsd_ser_sync.sv
// Module: multi-flop synchronizer for a bundle of asynchronous inputs.
// Assumes: each bit is independent; STAGES >= 2; reset clears every flop.
module lsd_ser_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= d_i;
                end
            end else begin : g_next
                // Pass the value one flop further down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/lsd_ser_edge.sv
// Module: rise/fall detector for a vector of synchronized levels.
// Assumes: inputs are already in the clk domain; reset sets history to 0.
module lsd_ser_edge #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    logic [WIDTH-1:0] prev_q;

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;

endmodule

// File: rtl/lsd_ser_seq.sv
// Module: decides each cycle whether the chain shifts, loads faults or is
// copied to the output register.
// Assumes: edge events are single-cycle pulses; clear has priority.
module lsd_ser_seq
    import lsd_ser_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear_i,
    input  logic        latch_i,
    input  ser_events_t ev_i,
    output logic        shift_o,
    output logic        load_o,
    output logic        copy_o
);

    logic snap_armed_q;
    logic snap_now;

    // A snapshot is owed from the latch rise until the first falling edge.
    assign snap_now = latch_i & ev_i.sclk_fall & (snap_armed_q | ev_i.latch_rise);

    // Track whether the fault snapshot is still pending in this read phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)     snap_armed_q <= 1'b0;
        else if (!latch_i)         snap_armed_q <= 1'b0;
        else if (ev_i.sclk_fall)   snap_armed_q <= 1'b0;
        else                       snap_armed_q <= snap_armed_q | ev_i.latch_rise;
    end

    assign load_o  = snap_now & ~clear_i;
    assign shift_o = ~clear_i & ((~latch_i & ev_i.sclk_rise) |
                                 (latch_i & ev_i.sclk_fall & ~snap_now));
    assign copy_o  = ~clear_i & ev_i.latch_rise;

endmodule

// File: rtl/lsd_ser_chain.sv
// Module: the shift chain shared by write data and fault read-back.
// Assumes: at most one of shift/load per cycle; clear wins over both.
module lsd_ser_chain #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         shift_i,
    input  logic         load_i,
    input  logic         ser_i,
    input  logic [N-1:0] par_i,
    output logic [N-1:0] q_o,
    output logic         ser_o
);

    logic [N-1:0] chain_q;

    // Shift toward the top stage, or take a parallel snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) chain_q <= '0;
        else if (load_i)       chain_q <= par_i;
        else if (shift_i)      chain_q <= {chain_q[N-2:0], ser_i};
    end

    assign q_o   = chain_q;
    assign ser_o = chain_q[N-1];

endmodule

// File: rtl/lsd_ser_drive.sv
// Module: output register and enable gating for the channel switches.
// Assumes: en_n_i is synchronized; gating never alters the stored value.
module lsd_ser_drive #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         copy_i,
    input  logic         en_n_i,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] held_o,
    output logic [N-1:0] drive_o
);

    logic [N-1:0] held_q;

    // Capture the chain on a latch rise, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) held_q <= '0;
        else if (copy_i)       held_q <= d_i;
    end

    assign held_o  = held_q;
    assign drive_o = en_n_i ? '0 : held_q;

endmodule

// File: rtl/lsd_serial_slave.sv
// Module: daisy-chainable output/fault shift register (top).
// Assumes: clk runs several times faster than sclk_i; fault_i is in the
// clk domain; all other control pins are asynchronous.
module lsd_serial_slave
    import lsd_ser_pkg::*;
#(
    parameter int CHANNELS    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk_i,
    input  logic                sdat_i,
    input  logic                latch_i,
    input  logic                clear_i,
    input  logic                en_n_i,
    input  logic [CHANNELS-1:0] fault_i,
    output logic                sdat_o,
    output logic [CHANNELS-1:0] drive_o
);

    localparam int EDGE_W = 2;

    ser_pins_t             pins_raw;
    ser_pins_t             pins_s;
    logic [EDGE_W-1:0]     edge_rise;
    logic [EDGE_W-1:0]     edge_fall;
    ser_events_t           ev;
    logic                  shift_en;
    logic                  load_en;
    logic                  copy_en;
    logic [CHANNELS-1:0]   chain_q;
    logic [CHANNELS-1:0]   held_q;

    assign pins_raw = '{clear: clear_i, en_n: en_n_i, latch: latch_i,
                        sclk: sclk_i, sdat: sdat_i};

    lsd_ser_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (pins_raw),
        .q_o  (pins_s)
    );

    lsd_ser_edge #(.WIDTH(EDGE_W)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i ({pins_s.latch, pins_s.sclk}),
        .rise_o(edge_rise),
        .fall_o(edge_fall)
    );

    assign ev = '{sclk_rise: edge_rise[0], sclk_fall: edge_fall[0],
                  latch_rise: edge_rise[1]};

    lsd_ser_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(pins_s.clear),
        .latch_i(pins_s.latch),
        .ev_i   (ev),
        .shift_o(shift_en),
        .load_o (load_en),
        .copy_o (copy_en)
    );

    lsd_ser_chain #(.N(CHANNELS)) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(pins_s.clear),
        .shift_i(shift_en),
        .load_i (load_en),
        .ser_i  (pins_s.sdat),
        .par_i  (fault_i),
        .q_o    (chain_q),
        .ser_o  (sdat_o)
    );

    lsd_ser_drive #(.N(CHANNELS)) u_drive (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(pins_s.clear),
        .copy_i (copy_en),
        .en_n_i (pins_s.en_n),
        .d_i    (chain_q),
        .held_o (held_q),
        .drive_o(drive_o)
    );

endmodule

// File: rtl/lsd_ser_chk.sv
// Module: property checker for lsd_serial_slave, attached by bind.
// Assumes: connected to the top's synchronized pins and internal registers.
module lsd_ser_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clear_s,
    input logic         latch_s,
    input logic         dat_s,
    input logic         en_n_s,
    input logic         sclk_rise,
    input logic         sclk_fall,
    input logic         latch_rise,
    input logic         load_en,
    input logic [N-1:0] fault,
    input logic [N-1:0] chain,
    input logic [N-1:0] held,
    input logic [N-1:0] drive
);

    // R2
    write_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && !latch_s && !clear_s) |=>
            chain == {$past(chain[N-2:0]), $past(dat_s)});

    // R4
    copy_on_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_rise && !clear_s) |=> held == $past(chain));

    // R4
    hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_rise && !clear_s) |=> $stable(held));

    // R5
    fault_snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> chain == $past(fault));

    // R7
    quiet_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_rise && !sclk_fall && !clear_s) |=> $stable(chain));

    // R8
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_n_s |-> drive == '0);

    // R9
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_s |=> (chain == '0 && held == '0));

endmodule

bind lsd_serial_slave lsd_ser_chk #(.N(CHANNELS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_s   (pins_s.clear),
    .latch_s   (pins_s.latch),
    .dat_s     (pins_s.sdat),
    .en_n_s    (pins_s.en_n),
    .sclk_rise (ev.sclk_rise),
    .sclk_fall (ev.sclk_fall),
    .latch_rise(ev.latch_rise),
    .load_en   (load_en),
    .fault     (fault_i),
    .chain     (chain_q),
    .held      (held_q),
    .drive     (drive_o)
);

// File: tb/lsd_serial_slave_bench.sv
// Bench: directed frames plus random traffic against a behavioural model.
module lsd_serial_slave_bench;

    localparam int N    = 4;
    localparam int SYNC = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b0, sdat = 1'b0, latch = 1'b0, clr = 1'b0, en_n = 1'b0;
    logic [N-1:0] fault = '0;
    logic         sdat_o;
    logic [N-1:0] drive_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    lsd_serial_slave #(.CHANNELS(N), .SYNC_STAGES(SYNC)) u_lsd_serial_slave (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdat_i(sdat), .latch_i(latch),
        .clear_i(clr), .en_n_i(en_n), .fault_i(fault),
        .sdat_o(sdat_o), .drive_o(drive_o)
    );

    // ---------------- behavioural model ----------------
    logic [4:0]   hist [SYNC];
    logic [N-1:0] m_sh, m_drv;
    bit           m_pend, m_en_n, m_live, p_sc, p_lat;

    initial begin
        foreach (hist[i]) hist[i] = '0;
        m_sh = '0; m_drv = '0; m_pend = 0; m_en_n = 0; m_live = 0; p_sc = 0; p_lat = 0;
    end

    always @(posedge clk) begin
        logic [4:0] u;
        bit rise, fall, lrise;
        m_live = rst_n;
        if (!rst_n) begin
            foreach (hist[i]) hist[i] = '0;
            m_sh = '0; m_drv = '0; m_pend = 0; m_en_n = 0; p_sc = 0; p_lat = 0;
        end else begin
            u = hist[SYNC-1];
            for (int i = SYNC-1; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = {clr, en_n, latch, sclk, sdat};
            rise  = u[1] && !p_sc;
            fall  = !u[1] && p_sc;
            lrise = u[2] && !p_lat;
            p_sc  = u[1];
            p_lat = u[2];
            if (u[4]) begin
                m_sh = '0; m_drv = '0; m_pend = 0;
            end else begin
                if (lrise) m_drv = m_sh;
                if (u[2] && fall) m_sh = (m_pend || lrise) ? fault : {m_sh[N-2:0], u[0]};
                else if (!u[2] && rise) m_sh = {m_sh[N-2:0], u[0]};
                m_pend = u[2] && !fall && (m_pend || lrise);
            end
            m_en_n = hist[SYNC-1][3];
        end
    end

    // Compare both outputs with the model every cycle (R3, R4, R8).
    always @(negedge clk) begin
        if (m_live && !done) begin
            checks += 2;
            if (sdat_o !== m_sh[N-1]) begin
                fails++;
                $display("FAIL R3 model sdat_o actual=%b expected=%b t=%0t", sdat_o, m_sh[N-1], $time);
            end
            if (drive_o !== (m_en_n ? '0 : m_drv)) begin
                fails++;
                $display("FAIL R4 model drive_o actual=%b expected=%b t=%0t",
                         drive_o, (m_en_n ? '0 : m_drv), $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic b);
        sdat = b; wait_n(4);
        sclk = 1'b1; wait_n(4);
        sclk = 1'b0; wait_n(4);
    endtask

    task automatic write4(input logic [N-1:0] f);
        for (int i = N-1; i >= 0; i--) pulse(f[i]);
    endtask

    task automatic set_latch(input logic v);
        latch = v; wait_n(4);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // ---------------- directed and random stimulus ----------------
    initial begin
        wait_n(5);
        // R1: reset state
        chk("R1 reset drive_o", drive_o, '0);
        chk("R1 reset sdat_o", {3'b0, sdat_o}, '0);
        rst_n = 1'b1;
        wait_n(4);

        // R2/R3/R4: frame 1011, first bit lands on top channel
        write4(4'b1011);
        chk("R4 drive before latch", drive_o, '0);
        chk("R3 sdat_o top stage", {3'b0, sdat_o}, 4'b0001);
        set_latch(1'b1);
        chk("R2 frame 1011 on drive", drive_o, 4'b1011);
        set_latch(1'b0);

        // R7: falls in write phase do not shift
        write4(4'b1000);
        chk("R7 falls ignored, first bit still on top", {3'b0, sdat_o}, 4'b0001);
        chk("R2 first bit on channel 4 pending", drive_o, 4'b1011);
        set_latch(1'b1);
        chk("R2 first-in bit drives top channel", drive_o, 4'b1000);
        set_latch(1'b0);

        // R3: chaining, fifth shift exposes second frame bit
        write4(4'b1011);
        pulse(1'b0);
        chk("R3 chain passes second bit", {3'b0, sdat_o}, 4'b0000);

        // R8: enable gating leaves serial logic alone
        en_n = 1'b1; wait_n(4);
        chk("R8 disabled drive_o", drive_o, '0);
        write4(4'b0110);
        set_latch(1'b1); set_latch(1'b0);
        chk("R8 still off while disabled", drive_o, '0);
        en_n = 1'b0; wait_n(4);
        chk("R8 stored value after enable", drive_o, 4'b0110);

        // R5/R6: fault read-back
        write4(4'b0101);
        fault = 4'b1101;
        set_latch(1'b1);
        chk("R4 copy at read start", drive_o, 4'b0101);
        chk("R5 no load before first fall", {3'b0, sdat_o}, 4'b0000);
        pulse(1'b0);
        chk("R5 fault bit 4 after first fall", {3'b0, sdat_o}, 4'b0001);
        fault = 4'b0000;
        pulse(1'b0);
        chk("R6 fault bit 3", {3'b0, sdat_o}, 4'b0001);
        pulse(1'b1);
        chk("R6 fault bit 2", {3'b0, sdat_o}, 4'b0000);
        pulse(1'b1);
        chk("R6 fault bit 1", {3'b0, sdat_o}, 4'b0001);
        pulse(1'b0);
        chk("R6 injected bit follows faults", {3'b0, sdat_o}, 4'b0000);
        chk("R4 drive held during read", drive_o, 4'b0101);
        set_latch(1'b0);

        // R5: latch rise and sclk fall reach the core together
        write4(4'b0000);
        sclk = 1'b1; wait_n(4);
        fault = 4'b1000;
        latch = 1'b1; sclk = 1'b0; wait_n(6);
        chk("R5 coincident fall takes snapshot", {3'b0, sdat_o}, 4'b0001);
        set_latch(1'b0);
        fault = '0;

        // R9: clear
        write4(4'b1111);
        set_latch(1'b1); set_latch(1'b0);
        chk("R9 before clear", drive_o, 4'b1111);
        clr = 1'b1; wait_n(4); clr = 1'b0; wait_n(4);
        chk("R9 drive cleared", drive_o, '0);
        chk("R9 chain cleared", {3'b0, sdat_o}, '0);

        // Random traffic, compared by the model every cycle
        for (int it = 0; it < 150; it++) begin
            write4(N'($urandom));
            fault = N'($urandom);
            if ($urandom_range(0, 3) == 0) begin
                sclk = 1'b1; wait_n(4);
                latch = 1'b1; sclk = 1'b0; wait_n(4);
            end else begin
                set_latch(1'b1);
            end
            for (int k = 0; k < int'($urandom_range(0, 5)); k++) pulse(1'($urandom));
            set_latch(1'b0);
            en_n = ($urandom_range(0, 4) == 0);
            if ($urandom_range(0, 9) == 0) begin
                clr = 1'b1; wait_n(4); clr = 1'b0;
            end
            wait_n(2);
        end

        // R1: reset in mid-run
        write4(4'b1001);
        set_latch(1'b1); set_latch(1'b0);
        en_n = 1'b0;
        rst_n = 1'b0; wait_n(4);
        chk("R1 mid-run reset drive_o", drive_o, '0);
        chk("R1 mid-run reset sdat_o", {3'b0, sdat_o}, '0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule